// File: doc/BRIEF.md
# Base-Limit Address Relocation and Protection Unit

This block sits on the request path between a processor and its memory. Every address a user process issues is checked against a limit register and then relocated by adding a base register. An access that falls outside the permitted window is dropped and answered with a one-cycle trap pulse, so the operating system can take over. Requests made in supervisor mode go through unchanged and are not checked.

The base register holds the lowest physical address the running process may touch. The limit register holds the length of that window. Both registers are loaded through a small configuration port. The port accepts a write only while the mode input says supervisor. A write attempted in user mode is discarded and raises the trap. Each request gets its answer one clock later, either a physical address with a valid strobe or a trap. For example, with a base of 14000, logical address 346 comes out as 14346.

Top module: `reloc_guard`

## Requirements
- R1: After reset, base and limit are both 0 and the outputs `phys_valid` and `trap` are low. Every user-mode request therefore traps until limit is loaded.
- R2: A configuration write with `user_mode` low loads `cfg_wdata` into base when `cfg_sel` is 0, or into limit when `cfg_sel` is 1. The new value applies to requests from the next cycle onward, and the write itself raises neither `trap` nor `phys_valid`.
- R3: A configuration write with `user_mode` high leaves both registers unchanged and raises `trap` in the following cycle.
- R4: A legal user-mode request produces `phys_valid` high one cycle later, with `phys_addr` equal to base plus the logical address.
- R5: A user-mode request whose logical address is not below limit (address >= limit) produces `trap` one cycle later and no `phys_valid`. Address limit-1 is still legal.
- R6: A user-mode request for which base plus the logical address does not fit in AW bits produces `trap` one cycle later and no `phys_valid`.
- R7: A supervisor-mode request (`user_mode` low) produces `phys_valid` one cycle later, with `phys_addr` equal to the logical address. No range check is applied.
- R8: `phys_valid` and `trap` are never high together. Each is a one-cycle pulse, raised only in the cycle after a request or a configuration write that causes it.
- R9: When `phys_valid` is high, `phys_write` equals the `req_write` flag of the request that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| user_mode | input | 1 | 1 = user mode, 0 = supervisor. Applies to both the request and the configuration write in the same cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 = base, 1 = limit |
| cfg_wdata | input | AW | Value to write |
| req_valid | input | 1 | Request strobe |
| req_addr | input | AW | Logical address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| phys_valid | output | 1 | Translated access forwarded to memory |
| phys_addr | output | AW | Physical address, meaningful while phys_valid is high |
| phys_write | output | 1 | Access direction, meaningful while phys_valid is high |
| trap | output | 1 | Protection violation pulse |

## Verification
A wrong base value shows up as a shifted `phys_addr` on the very next legal user request. The bench checks exact sums, including the carry boundary, where a wrap would turn a trap into a bogus valid. A wrong limit moves the edge between valid and trap, so the bench probes addresses limit-1 and limit right after each load. A configuration write that leaks through in user mode is caught within two cycles: the next user request still shows the old base.

// File: rtl/reloc_pkg.sv
package reloc_pkg;

    // Register select on the configuration port
    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_LIMIT = 1'b1
    } reloc_sel_e;

    // Mode input encoding
    localparam logic MODE_SUPER = 1'b0;
    localparam logic MODE_USER  = 1'b1;

endpackage

// File: rtl/reloc_regs.sv
module reloc_regs
    import reloc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          user_mode,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] limit_q,
    output logic          cfg_fault
);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] limit;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ok;

    always_comb begin
        wr_ok     = cfg_we && (user_mode == MODE_SUPER);
        cfg_fault = cfg_we && (user_mode == MODE_USER);
        r_d       = r_q;
        if (wr_ok) begin
            if (reloc_sel_e'(cfg_sel) == SEL_BASE) begin
                r_d.base = cfg_wdata;
            end else begin
                r_d.limit = cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign base_q  = r_q.base;
    assign limit_q = r_q.limit;

endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate
    import reloc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          user_mode,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic [AW-1:0] phys,
    output logic          legal
);

    localparam int SW = AW + 1;

    logic [SW-1:0] sum;
    logic          below_limit;
    logic          carry;

    always_comb begin
        sum         = {1'b0, base} + {1'b0, addr};
        carry       = sum[SW-1];
        below_limit = addr < limit;
        if (user_mode == MODE_USER) begin
            phys  = sum[AW-1:0];
            legal = below_limit && !carry;
        end else begin
            phys  = addr;
            legal = 1'b1;
        end
    end

endmodule

// File: rtl/reloc_guard.sv
module reloc_guard
    import reloc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          user_mode,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    output logic          phys_valid,
    output logic [AW-1:0] phys_addr,
    output logic          phys_write,
    output logic          trap
);

    typedef struct packed {
        logic          valid;
        logic          trap;
        logic          write;
        logic [AW-1:0] addr;
    } out_t;

    logic [AW-1:0] base_q;
    logic [AW-1:0] limit_q;
    logic          cfg_fault;
    logic [AW-1:0] xl_phys;
    logic          xl_legal;

    out_t o_d, o_q;

    reloc_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .user_mode (user_mode),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .base_q    (base_q),
        .limit_q   (limit_q),
        .cfg_fault (cfg_fault)
    );

    reloc_xlate #(.AW(AW)) u_xlate (
        .user_mode (user_mode),
        .addr      (req_addr),
        .base      (base_q),
        .limit     (limit_q),
        .phys      (xl_phys),
        .legal     (xl_legal)
    );

    always_comb begin
        o_d       = '0;
        o_d.addr  = o_q.addr;
        o_d.write = o_q.write;
        o_d.trap  = cfg_fault || (req_valid && !xl_legal);
        if (req_valid && xl_legal && !cfg_fault) begin
            o_d.valid = 1'b1;
            o_d.addr  = xl_phys;
            o_d.write = req_write;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign phys_valid = o_q.valid;
    assign phys_addr  = o_q.addr;
    assign phys_write = o_q.write;
    assign trap       = o_q.trap;

endmodule

// File: rtl/reloc_guard_chk.sv
module reloc_guard_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          user_mode,
    input logic          cfg_we,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic          req_write,
    input logic [AW-1:0] base_q,
    input logic [AW-1:0] limit_q,
    input logic          phys_valid,
    input logic [AW-1:0] phys_addr,
    input logic          phys_write,
    input logic          trap
);

    logic [AW:0] ck_sum;
    assign ck_sum = {1'b0, base_q} + {1'b0, req_addr};

    // R8
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(phys_valid && trap));

    // R8
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !cfg_we) |=> (!phys_valid && !trap));

    // R3
    a_r3_user_cfg_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && user_mode) |=> trap);

    // R3
    a_r3_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && !user_mode) |=> ($stable(base_q) && $stable(limit_q)));

    // R5
    a_r5_over_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && user_mode && (req_addr >= limit_q)) |=> (trap && !phys_valid));

    // R6
    a_r6_carry_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && user_mode && ck_sum[AW]) |=> (trap && !phys_valid));

    // R4
    a_r4_relocated: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && user_mode && !cfg_we && (req_addr < limit_q) && !ck_sum[AW])
        |=> (phys_valid && (phys_addr == $past(ck_sum[AW-1:0]))));

    // R7
    a_r7_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !user_mode) |=> (phys_valid && (phys_addr == $past(req_addr))));

    // R9
    a_r9_direction: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !user_mode) |=> (phys_write == $past(req_write)));

endmodule

bind reloc_guard reloc_guard_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .user_mode  (user_mode),
    .cfg_we     (cfg_we),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .base_q     (base_q),
    .limit_q    (limit_q),
    .phys_valid (phys_valid),
    .phys_addr  (phys_addr),
    .phys_write (phys_write),
    .trap       (trap)
);

// File: tb/reloc_guard_bench.sv
module reloc_guard_bench;

    localparam int AW = 16;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          user_mode = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic          phys_valid;
    logic [AW-1:0] phys_addr;
    logic          phys_write;
    logic          trap;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reloc_guard #(.AW(AW)) u_reloc_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .user_mode  (user_mode),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_write  (req_write),
        .phys_valid (phys_valid),
        .phys_addr  (phys_addr),
        .phys_write (phys_write),
        .trap       (trap)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one configuration write; outputs checked in the following cycle
    task automatic do_cfg(input logic sel, input logic [AW-1:0] val, input logic um,
                          input logic exp_trap, input string req);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val; user_mode = um;
        @(negedge clk);
        cfg_we = 1'b0; user_mode = 1'b0;
        check(trap == exp_trap, req, "cfg trap", 32'(trap), 32'(exp_trap));
        check(!phys_valid, req, "cfg valid", 32'(phys_valid), 32'h0);
    endtask

    // one request; exp_valid selects which outcome is expected
    task automatic do_req(input logic [AW-1:0] a, input logic wr, input logic um,
                          input logic exp_valid, input logic [AW-1:0] exp_addr,
                          input string req);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; user_mode = um;
        @(negedge clk);
        req_valid = 1'b0; user_mode = 1'b0;
        check(phys_valid == exp_valid, req, "valid", 32'(phys_valid), 32'(exp_valid));
        check(trap == !exp_valid, req, "trap", 32'(trap), 32'(!exp_valid));
        if (exp_valid) begin
            check(phys_addr == exp_addr, req, "phys_addr", 32'(phys_addr), 32'(exp_addr));
            check(phys_write == wr, "R9", "phys_write", 32'(phys_write), 32'(wr));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!phys_valid && !trap, "R1", "outputs after reset",
              {30'h0, phys_valid, trap}, 32'h0);
        // limit 0: every user access traps
        do_req(16'h0000, 1'b0, 1'b1, 1'b0, '0, "R1");
    endtask

    task automatic t_load_and_relocate();
        do_cfg(1'b0, 16'd14000, 1'b0, 1'b0, "R2");
        do_cfg(1'b1, 16'd1000, 1'b0, 1'b0, "R2");
        do_req(16'd346, 1'b0, 1'b1, 1'b1, 16'd14346, "R4");
        do_req(16'd0, 1'b1, 1'b1, 1'b1, 16'd14000, "R4");
        do_req(16'd999, 1'b1, 1'b1, 1'b1, 16'd14999, "R5");
        do_req(16'd1000, 1'b0, 1'b1, 1'b0, '0, "R5");
        do_req(16'hFFFF, 1'b0, 1'b1, 1'b0, '0, "R5");
    endtask

    task automatic t_user_cfg_blocked();
        do_cfg(1'b0, 16'd0, 1'b1, 1'b1, "R3");
        do_cfg(1'b1, 16'd5000, 1'b1, 1'b1, "R3");
        // base still 14000 and limit still 1000
        do_req(16'd346, 1'b0, 1'b1, 1'b1, 16'd14346, "R3");
        do_req(16'd1500, 1'b0, 1'b1, 1'b0, '0, "R3");
    endtask

    task automatic t_supervisor();
        do_req(16'hFFFF, 1'b1, 1'b0, 1'b1, 16'hFFFF, "R7");
        do_req(16'd346, 1'b0, 1'b0, 1'b1, 16'd346, "R7");
    endtask

    task automatic t_carry();
        do_cfg(1'b0, 16'hFF00, 1'b0, 1'b0, "R2");
        do_cfg(1'b1, 16'h0200, 1'b0, 1'b0, "R2");
        do_req(16'h00FF, 1'b1, 1'b1, 1'b1, 16'hFFFF, "R6");
        do_req(16'h0100, 1'b0, 1'b1, 1'b0, '0, "R6");
        do_req(16'h01FF, 1'b0, 1'b1, 1'b0, '0, "R6");
    endtask

    task automatic t_pulses();
        do_req(16'h0010, 1'b0, 1'b1, 1'b1, 16'hFF10, "R8");
        @(negedge clk);
        check(!phys_valid && !trap, "R8", "idle after request",
              {30'h0, phys_valid, trap}, 32'h0);
        do_req(16'h0300, 1'b0, 1'b1, 1'b0, '0, "R8");
        @(negedge clk);
        check(!phys_valid && !trap, "R8", "idle after trap",
              {30'h0, phys_valid, trap}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_and_relocate();
        t_user_cfg_blocked();
        t_supervisor();
        t_carry();
        t_pulses();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule